// File: doc/BRIEF.md
# Multi-Mode Supervisory Watchdog with Supply-Current Gating

This block supervises a host processor with an elapsed-tick counter. The counter advances on a tick from a local oscillator. Software services the watchdog with a trigger write. Each write carries an encoded period and a behaviour code, so every change of behaviour happens together with a service. The block has four behaviours:

- **Start-up**: a fixed initial period after every reset.
- **Window**: a trigger that comes too early or too late is a fault.
- **Time-out**: only a late or missing trigger is a fault.
- **Off**: the watchdog stays armed until the supervised supply current is low, and re-arms when the current rises again.

When the watchdog overflows, the block raises a one-cycle reset request. If software has set a one-shot interrupt-enable bit, the block raises an interrupt instead, and the bit clears itself. A raised interrupt must be acknowledged within a fixed number of ticks, or a reset is forced. If the oscillator is lost, the block drops into a fail-safe state. It holds the reset request there until the oscillator is good again and a wake-up event arrives.

The states are:

| State | Code | Meaning |
|-------|------|---------|
| ST_STARTUP | 0 | Start-up period running |
| ST_WINDOW | 1 | Window behaviour |
| ST_TIMEOUT | 2 | Time-out behaviour |
| ST_OFF_PEND | 3 | Off requested; counter still running until the current is low |
| ST_OFF | 4 | Counter frozen |
| ST_FAILSAFE | 5 | Oscillator fault |

The transitions are:

- **Fault**: any state goes to ST_STARTUP with a reset pulse.
- **Accept**: a legal trigger goes to the state its behaviour code names.
- **Gate**: ST_OFF_PEND goes to ST_OFF on the low-current flag.
- **Rearm**: ST_OFF goes to ST_OFF_PEND on the high-current flag.
- **Oscfail**: any state goes to ST_FAILSAFE.
- **Recover**: ST_FAILSAFE goes to ST_STARTUP on a wake-up event with the oscillator good.

Top module: `wdsup_watchdog`

## Requirements
- R1: After reset, wd_state is 0 (ST_STARTUP), and rst_req and wd_irq are low. With no trigger, a reset request follows INIT_TICKS ticks later. An overflow in Start-up always gives a reset, never an interrupt.
- R2: Period codes 1 to 10 are legal and select BASE_TICKS << (code-1) ticks. A trigger with code 0 or 11 to 15 gives a one-cycle rst_req pulse on the next cycle and returns to ST_STARTUP.
- R3: Behaviour codes are 1 = Time-out (state 2), 2 = Window (state 1) and 3 = Off (state 3). Code 0 is illegal and gives an immediate reset to ST_STARTUP.
- R4: In Window behaviour, a trigger arriving when fewer than half the period's ticks have elapsed is too early and gives a reset. A trigger with half or more elapsed is accepted.
- R5: In Time-out and Start-up, a trigger at any point before overflow is accepted.
- R6: An overflow with the interrupt bit clear gives a one-cycle rst_req pulse, and the state becomes ST_STARTUP.
- R7: Off selected while op_standby is 0 runs ST_OFF_PEND with the largest period (code 10). Off selected while op_standby is 1 keeps the period in use.
- R8: ST_OFF_PEND goes to ST_OFF when cur_low is high. In ST_OFF the counter is frozen and no reset occurs, however long it stays there. It leaves only when cur_high is high, returning to ST_OFF_PEND with the count restarted.
- R9: If irq_en_set has set the interrupt bit, an overflow outside Start-up raises wd_irq instead of a reset and clears the bit. The next overflow then resets. irq_ack clears wd_irq.
- R10: If wd_irq is not acknowledged within ACK_TICKS ticks of being raised, a reset to ST_STARTUP is forced and wd_irq drops.
- R11: When osc_ok is low, the next state is ST_FAILSAFE, and rst_req is held high there. The block leaves only on wake with osc_ok high, going to ST_STARTUP with a reset pulse.
- R12: A trigger at the same edge as an overflow wins: the service is accepted and no reset occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oscillator tick enable |
| osc_ok | input | 1 | Oscillator frequency good |
| wake | input | 1 | Wake-up event |
| trig_valid | input | 1 | Trigger write strobe |
| trig_code | input | 4 | Encoded period |
| trig_mode | input | 2 | Behaviour code |
| op_standby | input | 1 | Operating mode is Standby (1) or Normal (0) |
| irq_en_set | input | 1 | Set the one-shot interrupt-enable bit |
| irq_ack | input | 1 | Interrupt register read |
| cur_low | input | 1 | Supply current below low threshold |
| cur_high | input | 1 | Supply current above high threshold |
| rst_req | output | 1 | Reset request |
| wd_irq | output | 1 | Watchdog overflow interrupt |
| wd_state | output | 3 | Current state code |

## Verification
The bench probes the window split exactly at half the period and one tick before it; a design that rounds the wrong way resets on a legal service or lets an early one through. It places a trigger on the same edge as an overflow, which catches a priority mistake that would turn a valid service into a reset. It holds the block in ST_OFF for longer than the largest period and toggles the current flags inside the hysteresis band; a design that keeps counting, or that leaves on the low flag falling, would reset. It also checks that the one-shot interrupt bit really clears itself, that a silent interrupt ends in a reset, and that Off chosen from Normal and from Standby picks the largest and the last period respectively.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

    localparam int unsigned CODE_W    = 4;
    localparam int unsigned NUM_CODES = 10;

    typedef enum logic [2:0] {
        ST_STARTUP  = 3'd0,
        ST_WINDOW   = 3'd1,
        ST_TIMEOUT  = 3'd2,
        ST_OFF_PEND = 3'd3,
        ST_OFF      = 3'd4,
        ST_FAILSAFE = 3'd5
    } wd_state_t;

    localparam logic [1:0] MD_BAD     = 2'd0;
    localparam logic [1:0] MD_TIMEOUT = 2'd1;
    localparam logic [1:0] MD_WINDOW  = 2'd2;
    localparam logic [1:0] MD_OFF     = 2'd3;

endpackage

// File: rtl/wdsup_period_dec.sv
module wdsup_period_dec
    import wdsup_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 8,
    parameter int unsigned W          = 13
) (
    input  logic [CODE_W-1:0] code,
    output logic              legal,
    output logic [W-1:0]      ticks
);

    always_comb begin
        legal = (code != '0) && (code <= CODE_W'(NUM_CODES));
        ticks = legal ? (W'(BASE_TICKS) << (code - CODE_W'(1))) : '0;
    end

endmodule

// File: rtl/wdsup_tick_counter.sv
module wdsup_tick_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         expire
);

    logic [W-1:0] cnt_q;

    assign expire = run && tick && (cnt_q == limit - W'(1));
    assign count  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= expire ? '0 : cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/wdsup_watchdog.sv
module wdsup_watchdog
    import wdsup_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 8,
    parameter int unsigned INIT_TICKS = 64,
    parameter int unsigned ACK_TICKS  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        osc_ok,
    input  logic        wake,
    input  logic        trig_valid,
    input  logic [3:0]  trig_code,
    input  logic [1:0]  trig_mode,
    input  logic        op_standby,
    input  logic        irq_en_set,
    input  logic        irq_ack,
    input  logic        cur_low,
    input  logic        cur_high,
    output logic        rst_req,
    output logic        wd_irq,
    output logic [2:0]  wd_state
);

    localparam int unsigned MAX_TICKS = BASE_TICKS << (NUM_CODES - 1);
    localparam int unsigned LIM_MAX   = (MAX_TICKS > INIT_TICKS) ? MAX_TICKS : INIT_TICKS;
    localparam int unsigned CNT_W     = $clog2(LIM_MAX + 1);
    localparam int unsigned ACK_W     = $clog2(ACK_TICKS + 1);

    wd_state_t         state_q, state_d;
    logic [CNT_W-1:0]  ticks_q, ticks_d;
    logic              rst_q, rst_d;
    logic              irq_q, ien_q;
    logic              irq_raise, irq_drop, ien_drop, fail_over;
    logic              wd_clear, wd_run, wd_expire, early;
    logic [CNT_W-1:0]  wd_cnt, trig_ticks;
    logic              trig_legal;
    logic [ACK_W-1:0]  ack_cnt;
    logic              ack_expire;

    wdsup_period_dec #(.BASE_TICKS(BASE_TICKS), .W(CNT_W)) i_dec (
        .code  (trig_code),
        .legal (trig_legal),
        .ticks (trig_ticks)
    );

    assign wd_run = (state_q != ST_OFF) && (state_q != ST_FAILSAFE);

    wdsup_tick_counter #(.W(CNT_W)) i_wd_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (wd_clear),
        .run    (wd_run),
        .tick   (tick),
        .limit  (ticks_q),
        .count  (wd_cnt),
        .expire (wd_expire)
    );

    wdsup_tick_counter #(.W(ACK_W)) i_ack_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!irq_q),
        .run    (irq_q),
        .tick   (tick),
        .limit  (ACK_W'(ACK_TICKS)),
        .count  (ack_cnt),
        .expire (ack_expire)
    );

    assign early = wd_cnt < (ticks_q >> 1);

    // Next-state and event resolution
    always_comb begin
        state_d   = state_q;
        ticks_d   = ticks_q;
        rst_d     = 1'b0;
        wd_clear  = 1'b0;
        irq_raise = 1'b0;
        irq_drop  = irq_ack;
        ien_drop  = 1'b0;
        fail_over = 1'b0;
        if (!osc_ok) begin
            state_d  = ST_FAILSAFE;
            wd_clear = 1'b1;
            irq_drop = 1'b1;
            ien_drop = 1'b1;
        end else begin
            unique case (state_q)
                ST_FAILSAFE: begin
                    if (wake) begin
                        state_d  = ST_STARTUP;
                        ticks_d  = CNT_W'(INIT_TICKS);
                        rst_d    = 1'b1;
                        wd_clear = 1'b1;
                    end
                end
                default: begin
                    if (ack_expire && !irq_ack) begin
                        fail_over = 1'b1;
                    end else if (trig_valid) begin
                        if (!trig_legal || trig_mode == MD_BAD ||
                            (state_q == ST_WINDOW && early)) begin
                            fail_over = 1'b1;
                        end else begin
                            wd_clear = 1'b1;
                            case (trig_mode)
                                MD_TIMEOUT: begin
                                    state_d = ST_TIMEOUT;
                                    ticks_d = trig_ticks;
                                end
                                MD_WINDOW: begin
                                    state_d = ST_WINDOW;
                                    ticks_d = trig_ticks;
                                end
                                default: begin
                                    state_d = ST_OFF_PEND;
                                    ticks_d = op_standby ? ticks_q : CNT_W'(MAX_TICKS);
                                end
                            endcase
                        end
                    end else if (wd_expire) begin
                        if (ien_q && state_q != ST_STARTUP) begin
                            irq_raise = 1'b1;
                            ien_drop  = 1'b1;
                        end else begin
                            fail_over = 1'b1;
                        end
                    end else if (state_q == ST_OFF_PEND && cur_low) begin
                        state_d  = ST_OFF;
                        wd_clear = 1'b1;
                    end else if (state_q == ST_OFF && cur_high) begin
                        state_d  = ST_OFF_PEND;
                        wd_clear = 1'b1;
                    end
                end
            endcase
            if (fail_over) begin
                state_d  = ST_STARTUP;
                ticks_d  = CNT_W'(INIT_TICKS);
                rst_d    = 1'b1;
                wd_clear = 1'b1;
                irq_drop = 1'b1;
                ien_drop = 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STARTUP;
            ticks_q <= CNT_W'(INIT_TICKS);
            rst_q   <= 1'b0;
            irq_q   <= 1'b0;
            ien_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ticks_q <= ticks_d;
            rst_q   <= rst_d;
            if (irq_raise)     irq_q <= 1'b1;
            else if (irq_drop) irq_q <= 1'b0;
            if (ien_drop)        ien_q <= 1'b0;
            else if (irq_en_set) ien_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        rst_req  = rst_q || (state_q == ST_FAILSAFE);
        wd_irq   = irq_q;
        wd_state = state_q;
    end

endmodule

// File: rtl/wdsup_watchdog_chk.sv
module wdsup_watchdog_chk
    import wdsup_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       osc_ok,
    input logic       trig_valid,
    input logic [3:0] trig_code,
    input logic [1:0] trig_mode,
    input logic       cur_high,
    input logic       wd_irq,
    input logic       rst_req,
    input logic [2:0] wd_state
);

    // R11
    osc_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_ok |=> (wd_state == ST_FAILSAFE && rst_req));

    // R6
    reset_to_startup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && wd_state != ST_FAILSAFE) |-> wd_state == ST_STARTUP);

    // R2 R3
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && osc_ok && wd_state != ST_FAILSAFE &&
         (trig_code == 4'd0 || trig_code > 4'(NUM_CODES) || trig_mode == MD_BAD))
        |=> rst_req);

    // R8
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_state == ST_OFF && osc_ok && !trig_valid && !cur_high && !wd_irq)
        |=> (wd_state == ST_OFF && !rst_req));

    // R9
    irq_not_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_irq) |-> !rst_req);

endmodule

bind wdsup_watchdog wdsup_watchdog_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_ok     (osc_ok),
    .trig_valid (trig_valid),
    .trig_code  (trig_code),
    .trig_mode  (trig_mode),
    .cur_high   (cur_high),
    .wd_irq     (wd_irq),
    .rst_req    (rst_req),
    .wd_state   (wd_state)
);

// File: tb/test_wdsup_watchdog.sv
`timescale 1ns/1ps
module test_wdsup_watchdog;

    logic       clk = 1'b0;
    logic       rst_n, tick, osc_ok, wake, trig_valid;
    logic [3:0] trig_code;
    logic [1:0] trig_mode;
    logic       op_standby, irq_en_set, irq_ack, cur_low, cur_high;
    logic       rst_req, wd_irq;
    logic [2:0] wd_state;

    int checks = 0;
    int errors = 0;
    int nrst   = 0;
    int base;

    always #4 clk = ~clk;

    wdsup_watchdog i_wdsup_watchdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .osc_ok(osc_ok), .wake(wake),
        .trig_valid(trig_valid), .trig_code(trig_code), .trig_mode(trig_mode),
        .op_standby(op_standby), .irq_en_set(irq_en_set), .irq_ack(irq_ack),
        .cur_low(cur_low), .cur_high(cur_high),
        .rst_req(rst_req), .wd_irq(wd_irq), .wd_state(wd_state)
    );

    always @(negedge clk) if (rst_n && rst_req) nrst++;

    // {gap[18:11], code[10:7], mode[6:5], exp_resets[4:3], exp_state[2:0]}
    localparam logic [18:0] VEC [13] = '{
        {8'd5,  4'd2,  2'd2, 2'd0, 3'd1},
        {8'd10, 4'd2,  2'd2, 2'd0, 3'd1},
        {8'd3,  4'd2,  2'd2, 2'd1, 3'd0},
        {8'd5,  4'd1,  2'd1, 2'd0, 3'd2},
        {8'd0,  4'd1,  2'd1, 2'd0, 3'd2},
        {8'd7,  4'd3,  2'd1, 2'd0, 3'd2},
        {8'd2,  4'd11, 2'd1, 2'd1, 3'd0},
        {8'd2,  4'd0,  2'd2, 2'd1, 3'd0},
        {8'd2,  4'd2,  2'd0, 2'd1, 3'd0},
        {8'd2,  4'd2,  2'd2, 2'd0, 3'd1},
        {8'd20, 4'd2,  2'd2, 2'd1, 3'd1},
        {8'd8,  4'd2,  2'd2, 2'd0, 3'd1},
        {8'd7,  4'd2,  2'd2, 2'd1, 3'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic trig(input logic [3:0] c, input logic [1:0] m);
        trig_valid = 1'b1; trig_code = c; trig_mode = m;
        @(negedge clk);
        trig_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; tick = 1; osc_ok = 1; wake = 0; trig_valid = 0;
        trig_code = 0; trig_mode = 0; op_standby = 0; irq_en_set = 0;
        irq_ack = 0; cur_low = 0; cur_high = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 reset state", int'(wd_state), 0);
        chk("R1 reset rst_req", int'(rst_req), 0);
        chk("R1 reset wd_irq", int'(wd_irq), 0);
        step(59);
        chk("R1 no early startup reset", nrst, 0);
        step(6);
        chk("R1 startup overflow reset", nrst, 1);
        chk("R1 R6 state after overflow", int'(wd_state), 0);

        // Table walk: R2 R3 R4 R5 R6 R12
        foreach (VEC[i]) begin
            base = nrst;
            step(int'(VEC[i][18:11]));
            trig(VEC[i][10:7], VEC[i][6:5]);
            chk($sformatf("R2 R3 R4 R5 R6 R12 row %0d resets", i), nrst - base, int'(VEC[i][4:3]));
            chk($sformatf("R3 R4 row %0d state", i), int'(wd_state), int'(VEC[i][2:0]));
        end

        // R9 one-shot interrupt
        base = nrst;
        trig(4'd1, 2'd1);
        irq_en_set = 1; step(1); irq_en_set = 0;
        step(8);
        chk("R9 interrupt instead of reset", int'(wd_irq), 1);
        chk("R9 no reset on first overflow", nrst - base, 0);
        irq_ack = 1; step(1); irq_ack = 0;
        chk("R9 ack clears interrupt", int'(wd_irq), 0);
        step(9);
        chk("R9 second overflow resets", nrst - base, 1);
        chk("R9 R6 state startup", int'(wd_state), 0);

        // R10 acknowledge time limit
        base = nrst;
        trig(4'd1, 2'd1);
        irq_en_set = 1; step(1); irq_en_set = 0;
        step(8);
        chk("R10 interrupt raised", int'(wd_irq), 1);
        for (int k = 0; k < 6; k++) begin
            step(3); trig(4'd1, 2'd1);
        end
        chk("R10 no reset before limit", nrst - base, 0);
        for (int k = 0; k < 2; k++) begin
            step(3); trig(4'd1, 2'd1);
        end
        chk("R10 reset after limit", nrst - base, 1);
        chk("R10 interrupt dropped", int'(wd_irq), 0);

        // R7 R8 Off from Normal
        base = nrst;
        op_standby = 0;
        trig(4'd1, 2'd3);
        chk("R7 off pending", int'(wd_state), 3);
        step(100);
        chk("R7 max period from normal", nrst - base, 0);
        cur_low = 1; step(1); cur_low = 0;
        chk("R8 gated off", int'(wd_state), 4);
        step(4200);
        chk("R8 hysteresis holds off", int'(wd_state), 4);
        chk("R8 no reset while off", nrst - base, 0);
        cur_high = 1; step(1); cur_high = 0;
        chk("R8 rearm on high flag", int'(wd_state), 3);

        // R7 Off from Standby keeps last period
        op_standby = 1;
        trig(4'd1, 2'd1);
        base = nrst;
        step(2);
        trig(4'd3, 2'd3);
        step(5);
        chk("R7 standby off pending", int'(wd_state), 3);
        chk("R7 no reset before last period", nrst - base, 0);
        step(4);
        chk("R7 last period used in standby", nrst - base, 1);

        // R11 fail-safe
        osc_ok = 0; step(1);
        chk("R11 failsafe state", int'(wd_state), 5);
        chk("R11 reset held", int'(rst_req), 1);
        wake = 1; step(3);
        chk("R11 wake ignored while osc bad", int'(wd_state), 5);
        wake = 0; osc_ok = 1; step(3);
        chk("R11 osc good without wake", int'(wd_state), 5);
        wake = 1; step(1); wake = 0;
        chk("R11 recover to startup", int'(wd_state), 0);
        chk("R11 recover reset pulse", int'(rst_req), 1);
        step(1);
        chk("R11 pulse ends", int'(rst_req), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule